// File: doc/BRIEF.md
# Multiplexed DRAM Address Decoder

This block is the address front end of a one-megabit by one DRAM. A single 10-bit address bus carries two addresses per cycle. The row address comes first and is captured when the row strobe rises. The column address follows on the same pins and is captured when the column strobe rises. From the two captured words the block produces three things. First, it enables the memory blocks. Second, it gives the row index inside each active half-block, together with a local one-hot decode of its two low bits. Third, it gives the column preselect and pair bit, and a one-hot choice of one of four merged data lines. Read data from those four lines is narrowed to the single output bit. Write data goes out on the one chosen line.

The array is four blocks. Each block has two halves of 256 rows. Row bit 8 wakes only two of the four blocks. The other two stay idle for the whole cycle. The final line choice combines bit 9 from the row phase with bit 9 from the column phase. Reading is destructive, so a one-cycle restore pulse follows every row activation; it tells the array to write its sensed rows back.

Refresh uses the column-strobe-before-row-strobe ordering. The row comes from an internal 8-bit counter instead of the pins. All four blocks are opened, no column access takes place, and the counter advances when the row closes.

Top module: `mxdec_top`

## Requirements
- R1: On the first clock where `ras` is sampled high after being low, with `cas` low, `row_idx` takes `addr[7:0]` and `row_lsel` becomes one-hot at bit position `addr[1:0]`. Both are visible from the following cycle.
- R2: During an ordinary row cycle exactly two blocks are enabled. A captured row bit 8 of 0 gives `blk_en` = 4'b0011. A value of 1 gives 4'b1100.
- R3: On a `cas` rising sample while a row is open (not a refresh), `col_pre` takes `addr[8:1]` and `col_pair` takes `addr[0]`.
- R4: `line_sel` is one-hot at index {row bit 9, column bit 9} (row bit as MSB) while a column is held, and all zero otherwise.
- R5: `dout` equals `rd_lines` at the index selected by `line_sel`.
- R6: If `we` is high at the column capture, `wr_en` equals `line_sel` for exactly one cycle and `wr_data` equals the captured `din`. Only the addressed cell changes.
- R7: If `cas` is already high when `ras` rises, the cycle is a refresh. All four blocks are enabled, and `line_sel` and `wr_en` stay zero.
- R8: A refresh uses the internal counter as the row index and ignores `addr`. The counter increases by one when each refresh row closes, and wraps from 255 to 0.
- R9: `restore` is high for exactly the one cycle after every row closes (ordinary or refresh), and `blk_en` is then zero.
- R10: Ordinary row cycles never change the refresh counter.
- R11: After reset, `blk_en`, `row_lsel`, `line_sel`, `wr_en` and `restore` are zero and the refresh counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 10 | Multiplexed row/column address |
| ras | input | 1 | Row strobe, active high |
| cas | input | 1 | Column strobe, active high |
| we | input | 1 | Write request, sampled at column capture |
| din | input | 1 | Write data bit |
| rd_lines | input | 4 | Merged read lines from the array |
| blk_en | output | 4 | Block activation |
| row_idx | output | 8 | Row index inside each active half |
| row_lsel | output | 4 | Local one-hot decode of the row's low two bits |
| col_pre | output | 8 | Column preselect (column bits 8..1) |
| col_pair | output | 1 | Column bit 0 |
| line_sel | output | 4 | One-hot data line select |
| dout | output | 1 | Read data bit |
| wr_en | output | 4 | One-cycle per-line write strobe |
| wr_data | output | 1 | Write data to the array |
| restore | output | 1 | One-cycle write-back pulse after a row closes |

## Verification
A wrongly captured row or a wrong bank bit shows on `blk_en` and `row_idx` one cycle after the row strobe. A bad column register or a bad line select shows one cycle after the column strobe, as the wrong `dout` bit or a write landing on the wrong line. A lost or misplaced restore does not show right away. The array model inverts a row when it is sensed, so the loss appears as inverted data on the next read of that row. A counter that slips shows on `row_idx` during the next refresh. Data that a faulty refresh spoils shows on the read-back pass that follows the refresh sweep.

// File: rtl/mxdec_pkg.sv
package mxdec_pkg;
    localparam int ADDR_W     = 10;
    localparam int ROW_IDX_W  = 8;
    localparam int COL_PRE_W  = 8;
    localparam int NUM_BLOCKS = 4;
    localparam int NUM_LINES  = 4;
    localparam int NUM_LOCAL  = 4;
    localparam int LSEL_W     = $clog2(NUM_LOCAL);

    typedef struct packed {
        logic                 hi;    // bit 9, joins the line choice
        logic                 bank;  // bit 8, picks the block pair
        logic [ROW_IDX_W-1:0] idx;   // row within each half
    } row_addr_t;

    typedef struct packed {
        logic                 hi;    // bit 9, joins the line choice
        logic [COL_PRE_W-1:0] pre;   // bits 8..1
        logic                 pair;  // bit 0
    } col_addr_t;

    function automatic row_addr_t split_row(input logic [ADDR_W-1:0] a);
        row_addr_t r;
        r.hi   = a[ADDR_W-1];
        r.bank = a[ADDR_W-2];
        r.idx  = a[ROW_IDX_W-1:0];
        return r;
    endfunction

    function automatic col_addr_t split_col(input logic [ADDR_W-1:0] a);
        col_addr_t c;
        c.hi   = a[ADDR_W-1];
        c.pre  = a[COL_PRE_W:1];
        c.pair = a[0];
        return c;
    endfunction

    function automatic logic [NUM_LINES-1:0] line_onehot(input logic rhi, input logic chi);
        return NUM_LINES'(1) << {rhi, chi};
    endfunction
endpackage

// File: rtl/mxdec_row_stage.sv
module mxdec_row_stage
    import mxdec_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  ras_rise,
    input  logic                  ras_fall,
    input  logic                  cas,
    output row_addr_t             row_q,
    output logic                  row_open,
    output logic                  refresh,
    output logic                  restore
);
    logic [ROW_IDX_W-1:0] rcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q    <= '0;
            row_open <= 1'b0;
            refresh  <= 1'b0;
            restore  <= 1'b0;
            rcnt     <= '0;
        end else begin
            restore <= 1'b0;
            if (ras_rise) begin
                row_open <= 1'b1;
                refresh  <= cas;
                if (cas) begin
                    row_q.hi   <= 1'b0;
                    row_q.bank <= 1'b0;
                    row_q.idx  <= rcnt;
                end else begin
                    row_q <= split_row(addr);
                end
            end else if (ras_fall && row_open) begin
                row_open <= 1'b0;
                refresh  <= 1'b0;
                restore  <= 1'b1;
                if (refresh) rcnt <= rcnt + 1'b1;
            end
        end
    end

    assert_cnt_step_R8: assert property (@(posedge clk) disable iff (rst)
        (rcnt != $past(rcnt)) |-> (rcnt == ROW_IDX_W'($past(rcnt) + 1'b1)));
    assert_cnt_only_refresh_R10: assert property (@(posedge clk) disable iff (rst)
        (rcnt != $past(rcnt)) |-> ($past(refresh) && restore));
endmodule

// File: rtl/mxdec_col_stage.sv
module mxdec_col_stage
    import mxdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ras,
    input  logic              cas,
    input  logic              cas_rise,
    input  logic              row_open,
    input  logic              refresh,
    input  logic              we,
    input  logic              din,
    output col_addr_t         col_q,
    output logic              col_valid,
    output logic              wr_pulse,
    output logic              wr_bit
);
    logic take;
    assign take = cas_rise && ras && row_open && !refresh;

    always_ff @(posedge clk) begin
        if (rst) begin
            col_q     <= '0;
            col_valid <= 1'b0;
            wr_pulse  <= 1'b0;
            wr_bit    <= 1'b0;
        end else begin
            wr_pulse <= 1'b0;
            if (take) begin
                col_q     <= split_col(addr);
                col_valid <= 1'b1;
                wr_pulse  <= we;
                wr_bit    <= din;
            end else if (!ras || !cas) begin
                col_valid <= 1'b0;
            end
        end
    end

    assert_col_in_row_R3: assert property (@(posedge clk) disable iff (rst)
        col_valid |-> (row_open && !refresh));
endmodule

// File: rtl/mxdec_route.sv
module mxdec_route
    import mxdec_pkg::*;
(
    input  row_addr_t              row_q,
    input  logic                   row_open,
    input  logic                   refresh,
    input  col_addr_t              col_q,
    input  logic                   col_valid,
    input  logic                   wr_pulse,
    input  logic                   wr_bit,
    input  logic [NUM_LINES-1:0]   rd_lines,
    output logic [NUM_BLOCKS-1:0]  blk_en,
    output logic [NUM_LOCAL-1:0]   row_lsel,
    output logic [NUM_LINES-1:0]   line_sel,
    output logic                   dout,
    output logic [NUM_LINES-1:0]   wr_en,
    output logic                   wr_data
);
    localparam int HALF = NUM_BLOCKS / 2;

    for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
        localparam bit UPPER = (b >= HALF);
        assign blk_en[b] = row_open && (refresh || (row_q.bank == UPPER));
    end

    for (genvar i = 0; i < NUM_LOCAL; i++) begin : g_lsel
        assign row_lsel[i] = row_open && (row_q.idx[LSEL_W-1:0] == LSEL_W'(i));
    end

    assign line_sel = col_valid ? line_onehot(row_q.hi, col_q.hi) : '0;
    assign dout     = |(rd_lines & line_sel);
    assign wr_en    = wr_pulse ? line_sel : '0;
    assign wr_data  = wr_bit;
endmodule

// File: rtl/mxdec_top.sv
module mxdec_top
    import mxdec_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  ras,
    input  logic                  cas,
    input  logic                  we,
    input  logic                  din,
    input  logic [NUM_LINES-1:0]  rd_lines,
    output logic [NUM_BLOCKS-1:0] blk_en,
    output logic [ROW_IDX_W-1:0]  row_idx,
    output logic [NUM_LOCAL-1:0]  row_lsel,
    output logic [COL_PRE_W-1:0]  col_pre,
    output logic                  col_pair,
    output logic [NUM_LINES-1:0]  line_sel,
    output logic                  dout,
    output logic [NUM_LINES-1:0]  wr_en,
    output logic                  wr_data,
    output logic                  restore
);
    logic      ras_q, cas_q;
    logic      ras_rise, ras_fall, cas_rise;
    row_addr_t row_q;
    col_addr_t col_q;
    logic      row_open, refresh, col_valid, wr_pulse, wr_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            ras_q <= 1'b0;
            cas_q <= 1'b0;
        end else begin
            ras_q <= ras;
            cas_q <= cas;
        end
    end

    assign ras_rise = ras && !ras_q;
    assign ras_fall = !ras && ras_q;
    assign cas_rise = cas && !cas_q;

    mxdec_row_stage u_row (
        .clk(clk), .rst(rst), .addr(addr),
        .ras_rise(ras_rise), .ras_fall(ras_fall), .cas(cas),
        .row_q(row_q), .row_open(row_open), .refresh(refresh), .restore(restore)
    );

    mxdec_col_stage u_col (
        .clk(clk), .rst(rst), .addr(addr), .ras(ras), .cas(cas), .cas_rise(cas_rise),
        .row_open(row_open), .refresh(refresh), .we(we), .din(din),
        .col_q(col_q), .col_valid(col_valid), .wr_pulse(wr_pulse), .wr_bit(wr_bit)
    );

    mxdec_route u_route (
        .row_q(row_q), .row_open(row_open), .refresh(refresh),
        .col_q(col_q), .col_valid(col_valid), .wr_pulse(wr_pulse), .wr_bit(wr_bit),
        .rd_lines(rd_lines), .blk_en(blk_en), .row_lsel(row_lsel),
        .line_sel(line_sel), .dout(dout), .wr_en(wr_en), .wr_data(wr_data)
    );

    assign row_idx  = row_q.idx;
    assign col_pre  = col_q.pre;
    assign col_pair = col_q.pair;

    assert_two_blocks_R2: assert property (@(posedge clk) disable iff (rst)
        (row_open && !refresh) |-> ($countones(blk_en) == 2));
    assert_all_blocks_R7: assert property (@(posedge clk) disable iff (rst)
        (row_open && refresh) |-> (&blk_en));
    assert_no_col_refresh_R7: assert property (@(posedge clk) disable iff (rst)
        refresh |-> (line_sel == '0 && wr_en == '0));
    assert_line_onehot_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(line_sel));
    assert_wr_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en != '0) |=> (wr_en == '0));
    assert_restore_R9: assert property (@(posedge clk) disable iff (rst)
        restore |-> (!row_open && $past(row_open) && blk_en == '0));
    assert_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !row_open |-> (blk_en == '0 && row_lsel == '0));
endmodule

// File: tb/tb_mxdec_top.sv
`timescale 1ns/1ps
module tb_mxdec_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] addr = '0;
    logic       ras = 1'b0, cas = 1'b0, we = 1'b0, din = 1'b0;
    logic [3:0] rd_lines = '0;
    logic [3:0] blk_en, row_lsel, line_sel, wr_en;
    logic [7:0] row_idx, col_pre;
    logic       col_pair, dout, wr_data, restore;

    always #2.5 clk = ~clk;

    mxdec_top dut (
        .clk(clk), .rst(rst), .addr(addr), .ras(ras), .cas(cas), .we(we), .din(din),
        .rd_lines(rd_lines), .blk_en(blk_en), .row_idx(row_idx), .row_lsel(row_lsel),
        .col_pre(col_pre), .col_pair(col_pair), .line_sel(line_sel), .dout(dout),
        .wr_en(wr_en), .wr_data(wr_data), .restore(restore)
    );

    int  n_chk = 0, n_fail = 0;
    bit  mem[int];
    bit  expv[int];
    bit  sbuf[2][2048];
    bit  open_h[2];
    logic [7:0] open_idx;
    logic [7:0] exp_cnt = 8'd0;
    int unsigned wl_ra[$], wl_ca[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint ex);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, ex);
        end
    endtask

    function automatic int caddr(input bit ra9, input bit ra8, input logic [7:0] idx,
                                 input bit ca9, input logic [7:0] pre, input bit c0);
        return int'({ra9, ra8, idx, ca9, pre, c0});
    endfunction

    function automatic int addr_of(input logic [9:0] ra, input logic [9:0] ca);
        return caddr(ra[9], ra[8], ra[7:0], ca[9], ca[8:1], ca[0]);
    endfunction

    function automatic logic [3:0] exp_blk(input bit a8);
        return a8 ? 4'b1100 : 4'b0011;
    endfunction

    function automatic logic [3:0] exp_line(input bit r9, input bit c9);
        return 4'b0001 << {r9, c9};
    endfunction

    // Array model: sensing a row destroys it (cells inverted) until restore.
    task automatic model_open();
        open_idx = row_idx;
        for (int h = 0; h < 2; h++) begin
            open_h[h] = blk_en[2*h];
            if (open_h[h]) begin
                for (int i = 0; i < 2048; i++) begin
                    logic [10:0] ix = 11'(i);
                    int a = caddr(ix[10], h[0], open_idx, ix[9], ix[8:1], ix[0]);
                    bit v = mem.exists(a) ? mem[a] : 1'b0;
                    sbuf[h][i] = v;
                    mem[a] = ~v;
                end
            end
        end
    endtask

    task automatic model_close();
        for (int h = 0; h < 2; h++) begin
            if (open_h[h]) begin
                for (int i = 0; i < 2048; i++) begin
                    logic [10:0] ix = 11'(i);
                    mem[caddr(ix[10], h[0], open_idx, ix[9], ix[8:1], ix[0])] = sbuf[h][i];
                end
            end
            open_h[h] = 1'b0;
        end
    endtask

    task automatic access(input logic [9:0] ra, input logic [9:0] ca, input bit w, input bit d);
        int h;
        int a;
        @(negedge clk);
        addr = ra; ras = 1'b1;
        @(negedge clk);
        chk(blk_en == exp_blk(ra[8]), "R2", "blk_en", blk_en, exp_blk(ra[8]));
        chk(row_idx == ra[7:0], "R1", "row_idx", row_idx, ra[7:0]);
        chk(row_lsel == (4'b0001 << ra[1:0]), "R1", "row_lsel", row_lsel, 4'b0001 << ra[1:0]);
        model_open();
        addr = ca; cas = 1'b1; we = w; din = d;
        @(negedge clk);
        chk(col_pre == ca[8:1] && col_pair == ca[0], "R3", "col", {col_pre, col_pair}, ca[8:0]);
        chk(line_sel == exp_line(ra[9], ca[9]), "R4", "line_sel", line_sel, exp_line(ra[9], ca[9]));
        h = ra[8] ? 1 : 0;
        for (int k = 0; k < 4; k++) begin
            logic [1:0] kk = 2'(k);
            rd_lines[k] = sbuf[h][{kk, col_pre, col_pair}];
        end
        #1;
        a = addr_of(ra, ca);
        if (!w) begin
            bit e = expv.exists(a) ? expv[a] : 1'b0;
            chk(dout == e, "R5", "dout", dout, e);
        end else begin
            chk(wr_en == exp_line(ra[9], ca[9]), "R6", "wr_en", wr_en, exp_line(ra[9], ca[9]));
            chk(wr_data == d, "R6", "wr_data", wr_data, d);
            for (int k = 0; k < 4; k++) begin
                logic [1:0] kk = 2'(k);
                if (wr_en[k]) sbuf[h][{kk, col_pre, col_pair}] = wr_data;
            end
            expv[a] = d;
        end
        ras = 1'b0; cas = 1'b0; we = 1'b0;
        @(negedge clk);
        chk(restore == 1'b1 && blk_en == 4'b0, "R9", "restore/blk_en", {restore, blk_en}, 5'h10);
        chk(wr_en == 4'b0, "R6", "wr_en single cycle", wr_en, 0);
        model_close();
        @(negedge clk);
        chk(restore == 1'b0, "R9", "restore width", restore, 0);
    endtask

    task automatic do_refresh(input logic [9:0] junk);
        @(negedge clk);
        cas = 1'b1; addr = ~junk;
        @(negedge clk);
        ras = 1'b1; addr = junk;
        @(negedge clk);
        chk(blk_en == 4'hF, "R7", "refresh blk_en", blk_en, 4'hF);
        chk(row_idx == exp_cnt, "R8", "refresh row_idx", row_idx, exp_cnt);
        chk(line_sel == 4'b0 && wr_en == 4'b0, "R7", "no column", {line_sel, wr_en}, 0);
        model_open();
        ras = 1'b0; cas = 1'b0;
        @(negedge clk);
        chk(restore == 1'b1, "R9", "refresh restore", restore, 1);
        model_close();
        exp_cnt = exp_cnt + 8'd1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(blk_en == 0 && row_lsel == 0 && line_sel == 0 && wr_en == 0 && restore == 0,
            "R11", "reset outputs", {blk_en, row_lsel, line_sel, wr_en, restore}, 0);

        // Directed: every combination of row A9, row A8, column A9, two cells each
        for (int c = 0; c < 16; c++) begin
            logic [3:0] cc = 4'(c);
            logic [9:0] ra = {cc[2], cc[1], 8'(8'h11 * c + 3)};
            logic [9:0] ca = {cc[0], 8'(8'h2D * c), cc[3]};
            access(ra, ca, 1'b1, cc[0] ^ cc[1] ^ cc[3] ^ 1'b1);
            wl_ra.push_back(ra); wl_ca.push_back(ca);
        end
        for (int i = 0; i < wl_ra.size(); i++) access(wl_ra[i], wl_ca[i], 1'b0, 1'b0);

        // R6: neighbours differing only in column A0 keep separate values
        access(10'h2A5, 10'h1F0, 1'b1, 1'b1);
        access(10'h2A5, 10'h1F1, 1'b1, 1'b0);
        access(10'h2A5, 10'h1F0, 1'b0, 1'b0);
        access(10'h2A5, 10'h1F1, 1'b0, 1'b0);
        wl_ra.push_back(10'h2A5); wl_ca.push_back(10'h1F0);
        wl_ra.push_back(10'h2A5); wl_ca.push_back(10'h1F1);

        // Random writes then reads
        for (int i = 0; i < 40; i++) begin
            logic [9:0] ra = 10'($urandom);
            logic [9:0] ca = 10'($urandom);
            access(ra, ca, 1'b1, 1'($urandom));
            wl_ra.push_back(ra); wl_ca.push_back(ca);
        end
        for (int i = 0; i < wl_ra.size(); i++) access(wl_ra[i], wl_ca[i], 1'b0, 1'b0);

        // R10: no refresh has happened yet, counter still at 0
        @(negedge clk);
        cas = 1'b1;
        @(negedge clk);
        ras = 1'b1; addr = 10'h3C7;
        @(negedge clk);
        chk(row_idx == 8'd0, "R10", "counter after ordinary cycles", row_idx, 0);
        model_open();
        ras = 1'b0; cas = 1'b0;
        @(negedge clk);
        model_close();
        exp_cnt = 8'd1;

        // Full sweep plus wrap (R8)
        for (int i = 0; i < 258; i++) do_refresh(10'($urandom));
        chk(exp_cnt == 8'd3, "R8", "bench wrap bookkeeping", exp_cnt, 3);

        // Stored data survives refresh
        for (int i = 0; i < wl_ra.size(); i++) access(wl_ra[i], wl_ca[i], 1'b0, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule